// File: doc/BRIEF.md
# Station-Filtered Audio Playout Buffer

This block sits behind a byte-oriented serial receiver on a shared medium where every station hears every packet. Each packet opens with one header byte, followed by a fixed number of payload bytes that are 8-bit unsigned audio samples. The block decodes the header. It checks the destination field against the station's own address or against a broadcast wildcard. It keeps the payload only when one of them matches. Bytes of packets meant for other stations are still counted, so the parser stays aligned to the packet boundaries.

Kept samples go into a playout FIFO. Playback stays idle until the FIFO holds a fill threshold of samples. It then sends one sample to the DAC per sample period, with a strobe. The sample period comes from the rate field of the last accepted header. When the FIFO runs dry, the output goes back to mid-scale and playback waits for the threshold again. The source address of the last accepted header is kept on an output for display.

Top module: `audio_playout_buffer`

## Requirements
- R1: The header byte carries the rate field in bits [7:6], the destination address in bits [5:3] and the source address in bits [2:0]. A packet is accepted when the destination equals `station_id`.
- R2: The destination value 3'b111 is a wildcard, and every station accepts it whatever its `station_id`.
- R3: A packet that is not accepted still consumes exactly PAYLOAD_LEN bytes after its header (16 by default). None of those bytes reaches the DAC, even when one looks like a matching header. The byte that follows is decoded as the next header.
- R4: The payload bytes of accepted packets appear on `dac_sample` in arrival order, one per `dac_stb` pulse.
- R5: Playback starts only once the FIFO holds FILL_THRESHOLD samples (8 by default). The first strobe comes exactly two cycles plus one sample period after the byte that reached the threshold was presented.
- R6: Strobes are spaced CLK_HZ/RATE_LO_HZ cycles apart for rate field 2'b00 and CLK_HZ/RATE_HI_HZ cycles apart for 2'b01. Field values 2'b10 and 2'b11 use the low rate.
- R7: A sample period that finds the FIFO empty gives one strobe carrying 8'h80. No further strobes follow until the threshold is reached again, and `dac_sample` stays at 8'h80.
- R8: `last_src_id` takes the source field of each accepted header. It does not change on rejected headers, on payload bytes or while no byte arrives.
- R9: A synchronous `rst` empties the FIFO and returns the parser to header search. It also sets `dac_sample` to 8'h80, `dac_stb` to 0 and `last_src_id` to 0. Any partial packet is lost.
- R10: `dac_sample` changes only in a cycle where `dac_stb` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_vld | input | 1 | One-cycle pulse: `rx_byte` holds a received byte |
| rx_byte | input | 8 | Received byte |
| station_id | input | 3 | Address of this station |
| dac_sample | output | 8 | Sample to the DAC, unsigned, mid-scale 8'h80 |
| dac_stb | output | 1 | One-cycle pulse when a new sample is presented |
| last_src_id | output | 3 | Source address of the last accepted packet |

## Verification
A table of headers is run against several station addresses. It covers:
- exact-address hits at each of the two defined rates;
- a misdirected packet whose payload is made of bytes that would match the local address if they were mistaken for headers, which separates a correct byte count from a parser that resynchronises early;
- wildcard deliveries to several addresses;
- an undefined rate code, which shows whether it falls back to the slow period.

Directed cases hold a packet one byte short of the threshold to find the exact first-strobe cycle, and reset in the middle of a packet to show that leftover bytes neither play nor shift the parser. Every run also checks that the stream ends in a single mid-scale strobe and then stays quiet.

// File: rtl/audio_pkt_pkg.sv
package audio_pkt_pkg;

   localparam int SAMPLE_W = 8;
   localparam int ADDR_W   = 3;
   localparam int RATE_W   = 2;

   localparam logic [ADDR_W-1:0]   ADDR_ALL  = 3'b111;
   localparam logic [SAMPLE_W-1:0] MID_SCALE = 8'h80;
   localparam logic [RATE_W-1:0]   RATE_FAST = 2'b01;

   typedef struct packed {
      logic [RATE_W-1:0] rate;
      logic [ADDR_W-1:0] dst;
      logic [ADDR_W-1:0] src;
   } hdr_t;

   typedef enum logic [1:0] {
      PS_HDR  = 2'd0,
      PS_KEEP = 2'd1,
      PS_SKIP = 2'd2
   } parse_st_t;

   typedef enum logic {
      PL_IDLE = 1'b0,
      PL_RUN  = 1'b1
   } play_st_t;

endpackage

// File: rtl/apb_hdr_filter.sv
module apb_hdr_filter
   import audio_pkt_pkg::*;
#(
   parameter int PAYLOAD_LEN = 16
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                byte_vld,
   input  logic [SAMPLE_W-1:0] byte_data,
   input  logic [ADDR_W-1:0]   my_addr,
   output logic                keep_vld,
   output logic [SAMPLE_W-1:0] keep_data,
   output logic                rate_fast,
   output logic [ADDR_W-1:0]   src_addr
);

   localparam int CNT_W = (PAYLOAD_LEN > 1) ? $clog2(PAYLOAD_LEN) : 1;
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PAYLOAD_LEN - 1);

   parse_st_t        state;
   logic [CNT_W-1:0] idx;
   hdr_t             hdr;
   logic             addr_hit;

   assign hdr      = hdr_t'(byte_data);
   assign addr_hit = (hdr.dst == my_addr) || (hdr.dst == ADDR_ALL);

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= PS_HDR;
         idx       <= '0;
         rate_fast <= 1'b0;
         src_addr  <= '0;
      end else if (byte_vld) begin
         case (state)
            PS_HDR: begin
               idx <= '0;
               if (addr_hit) begin
                  state     <= PS_KEEP;
                  src_addr  <= hdr.src;
                  rate_fast <= (hdr.rate == RATE_FAST);
               end else begin
                  state <= PS_SKIP;
               end
            end
            PS_KEEP, PS_SKIP: begin
               if (idx == LAST_IDX) begin
                  state <= PS_HDR;
                  idx   <= '0;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            default: state <= PS_HDR;
         endcase
      end
   end

   assign keep_vld  = byte_vld && (state == PS_KEEP);
   assign keep_data = byte_data;

endmodule

// File: rtl/apb_sync_fifo.sv
module apb_sync_fifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 32
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         wr_en,
   input  logic [DATA_W-1:0]            wr_data,
   input  logic                         rd_en,
   output logic [DATA_W-1:0]            rd_data,
   output logic [$clog2(DEPTH+1)-1:0]   level,
   output logic                         empty,
   output logic                         full
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int LVL_W = $clog2(DEPTH + 1);
   localparam bit POW2  = (DEPTH == (1 << PTR_W));

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic              do_wr, do_rd;

   assign empty = (level == '0);
   assign full  = (level == LVL_W'(DEPTH));
   assign do_wr = wr_en && !full;
   assign do_rd = rd_en && !empty;

   generate
      if (POW2) begin : g_wrap_free
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_wr) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (do_wr) wr_ptr <= wr_nxt;
         if (do_rd) rd_ptr <= rd_nxt;
         case ({do_wr, do_rd})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   assign rd_data = mem[rd_ptr];

endmodule

// File: rtl/apb_rate_timer.sv
module apb_rate_timer #(
   parameter int SLOW_DIV = 25000,
   parameter int FAST_DIV = 12500
) (
   input  logic clk,
   input  logic rst,
   input  logic hold,
   input  logic fast,
   output logic tick
);

   localparam int MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
   localparam int CNT_W   = $clog2(MAX_DIV + 1);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last;

   assign last = fast ? CNT_W'(FAST_DIV - 1) : CNT_W'(SLOW_DIV - 1);
   assign tick = !hold && (cnt >= last);

   always_ff @(posedge clk) begin
      if (rst || hold) cnt <= '0;
      else if (tick)   cnt <= '0;
      else             cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/apb_playout_ctrl.sv
module apb_playout_ctrl
   import audio_pkt_pkg::*;
#(
   parameter int LVL_W     = 6,
   parameter int THRESHOLD = 8
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [LVL_W-1:0]    level,
   input  logic                empty,
   input  logic [SAMPLE_W-1:0] head,
   input  logic                tick,
   output logic                pop,
   output logic                timer_hold,
   output logic                running,
   output logic [SAMPLE_W-1:0] sample,
   output logic                strobe
);

   play_st_t state;

   assign running    = (state == PL_RUN);
   assign timer_hold = !running;
   assign pop        = running && tick && !empty;

   always_ff @(posedge clk) begin
      if (rst) begin
         state  <= PL_IDLE;
         sample <= MID_SCALE;
         strobe <= 1'b0;
      end else begin
         strobe <= 1'b0;
         case (state)
            PL_IDLE: begin
               if (level >= LVL_W'(THRESHOLD)) state <= PL_RUN;
            end
            PL_RUN: begin
               if (tick) begin
                  strobe <= 1'b1;
                  if (!empty) begin
                     sample <= head;
                  end else begin
                     sample <= MID_SCALE;
                     state  <= PL_IDLE;
                  end
               end
            end
            default: state <= PL_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/audio_playout_buffer.sv
module audio_playout_buffer
   import audio_pkt_pkg::*;
#(
   parameter int CLK_HZ         = 50_000_000,
   parameter int RATE_LO_HZ     = 2000,
   parameter int RATE_HI_HZ     = 4000,
   parameter int PAYLOAD_LEN    = 16,
   parameter int FIFO_DEPTH     = 32,
   parameter int FILL_THRESHOLD = 8
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       rx_vld,
   input  logic [7:0] rx_byte,
   input  logic [2:0] station_id,
   output logic [7:0] dac_sample,
   output logic       dac_stb,
   output logic [2:0] last_src_id
);

   localparam int SLOW_DIV = CLK_HZ / RATE_LO_HZ;
   localparam int FAST_DIV = CLK_HZ / RATE_HI_HZ;
   localparam int LVL_W    = $clog2(FIFO_DEPTH + 1);

   generate
      if (PAYLOAD_LEN < 2)
         $error("PAYLOAD_LEN must be at least 2");
      if (FIFO_DEPTH < 2)
         $error("FIFO_DEPTH must be at least 2");
      if (FILL_THRESHOLD < 1 || FILL_THRESHOLD > FIFO_DEPTH)
         $error("FILL_THRESHOLD must lie in 1..FIFO_DEPTH");
      if (SLOW_DIV < 2 || FAST_DIV < 2)
         $error("sample periods must be at least two clocks");
   endgenerate

   logic                keep_vld;
   logic [SAMPLE_W-1:0] keep_data;
   logic                rate_fast;
   logic [SAMPLE_W-1:0] head;
   logic [LVL_W-1:0]    fifo_count;
   logic                fifo_empty, fifo_full;
   logic                pop, tick, timer_hold, playing;

   apb_hdr_filter #(.PAYLOAD_LEN(PAYLOAD_LEN)) u_filter (
      .clk       (clk),
      .rst       (rst),
      .byte_vld  (rx_vld),
      .byte_data (rx_byte),
      .my_addr   (station_id),
      .keep_vld  (keep_vld),
      .keep_data (keep_data),
      .rate_fast (rate_fast),
      .src_addr  (last_src_id)
   );

   apb_sync_fifo #(.DATA_W(SAMPLE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (keep_vld),
      .wr_data (keep_data),
      .rd_en   (pop),
      .rd_data (head),
      .level   (fifo_count),
      .empty   (fifo_empty),
      .full    (fifo_full)
   );

   apb_rate_timer #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_timer (
      .clk  (clk),
      .rst  (rst),
      .hold (timer_hold),
      .fast (rate_fast),
      .tick (tick)
   );

   apb_playout_ctrl #(.LVL_W(LVL_W), .THRESHOLD(FILL_THRESHOLD)) u_ctrl (
      .clk        (clk),
      .rst        (rst),
      .level      (fifo_count),
      .empty      (fifo_empty),
      .head       (head),
      .tick       (tick),
      .pop        (pop),
      .timer_hold (timer_hold),
      .running    (playing),
      .sample     (dac_sample),
      .strobe     (dac_stb)
   );

endmodule

// File: rtl/audio_playout_buffer_chk.sv
module audio_playout_buffer_chk #(
   parameter int FIFO_DEPTH     = 32,
   parameter int FILL_THRESHOLD = 8
) (
   input logic                          clk,
   input logic                          rst,
   input logic                          rx_vld,
   input logic [7:0]                    dac_sample,
   input logic                          dac_stb,
   input logic [2:0]                    last_src_id,
   input logic                          playing,
   input logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_count
);

   logic seen;

   always_ff @(posedge clk) begin
      if (rst) seen <= 1'b0;
      else     seen <= 1'b1;
   end

   AST_RESET_STATE: assert property (@(posedge clk)
      rst |=> (dac_sample == 8'h80 && !dac_stb && last_src_id == 3'd0)); // R9

   AST_SRC_HOLD: assert property (@(posedge clk) disable iff (rst)
      !rx_vld |=> $stable(last_src_id)); // R8

   AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (rst)
      fifo_count <= ($clog2(FIFO_DEPTH+1))'(FIFO_DEPTH)); // R4

   AST_START_FILL: assert property (@(posedge clk) disable iff (rst)
      (seen && playing && !$past(playing))
         |-> $past(fifo_count) >= ($clog2(FIFO_DEPTH+1))'(FILL_THRESHOLD)); // R5

   AST_NO_IDLE_STB: assert property (@(posedge clk) disable iff (rst)
      (seen && !playing && !$past(playing)) |-> !dac_stb); // R7

   AST_DAC_HOLD: assert property (@(posedge clk) disable iff (rst)
      (seen && !dac_stb) |-> dac_sample == $past(dac_sample)); // R10

endmodule

bind audio_playout_buffer audio_playout_buffer_chk #(
   .FIFO_DEPTH     (FIFO_DEPTH),
   .FILL_THRESHOLD (FILL_THRESHOLD)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .rx_vld      (rx_vld),
   .dac_sample  (dac_sample),
   .dac_stb     (dac_stb),
   .last_src_id (last_src_id),
   .playing     (playing),
   .fifo_count  (fifo_count)
);

// File: tb/audio_playout_buffer_tb.sv
`timescale 1ns/1ps
module audio_playout_buffer_tb;

   localparam int CLK_HZ = 80_000;
   localparam int LO_DIV = CLK_HZ / 2000;
   localparam int HI_DIV = CLK_HZ / 4000;
   localparam int DRAIN  = 18 * LO_DIV + 60;

   // {station_id[2:0], header[7:0], accept}
   localparam logic [11:0] VEC [0:7] = '{
      {3'd3, 2'b00, 3'd3, 3'd5, 1'b1},
      {3'd3, 2'b01, 3'd3, 3'd2, 1'b1},
      {3'd3, 2'b00, 3'd4, 3'd6, 1'b0},
      {3'd6, 2'b01, 3'd7, 3'd1, 1'b1},
      {3'd0, 2'b00, 3'd7, 3'd4, 1'b1},
      {3'd0, 2'b10, 3'd0, 3'd3, 1'b1},
      {3'd7, 2'b00, 3'd6, 3'd7, 1'b0},
      {3'd7, 2'b01, 3'd7, 3'd2, 1'b1}
   };

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       rx_vld = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic [2:0] station_id = 3'd0;
   logic [7:0] dac_sample;
   logic       dac_stb;
   logic [2:0] last_src_id;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int n_stb  = 0;
   int hold_bad = 0;
   bit done   = 1'b0;
   logic [7:0] stb_data [64];
   int         stb_time [64];
   logic [7:0] prev_dac = 8'h80;
   bit         mon_on = 1'b0;

   always #10 clk = ~clk;

   audio_playout_buffer #(.CLK_HZ(CLK_HZ)) u_dut (
      .clk         (clk),
      .rst         (rst),
      .rx_vld      (rx_vld),
      .rx_byte     (rx_byte),
      .station_id  (station_id),
      .dac_sample  (dac_sample),
      .dac_stb     (dac_stb),
      .last_src_id (last_src_id)
   );

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (!rst && mon_on) begin
         if (dac_stb && n_stb < 64) begin
            stb_data[n_stb] = dac_sample;
            stb_time[n_stb] = cyc;
            n_stb = n_stb + 1;
         end
         if (!dac_stb && dac_sample !== prev_dac) hold_bad = hold_bad + 1;
      end
      prev_dac = dac_sample;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic send_byte(input logic [7:0] b);
      @(negedge clk);
      rx_byte = b;
      rx_vld  = 1'b1;
      @(negedge clk);
      rx_vld  = 1'b0;
   endtask

   task automatic verify_stream(input logic [7:0] base, input int div,
                                input string req);
      chk(n_stb == 17, req, "strobe count", n_stb, 17);
      if (n_stb == 17) begin
         for (int i = 0; i < 16; i++)
            chk(stb_data[i] == 8'(base + i), "R4", "sample value",
                stb_data[i], 8'(base + i));
         for (int i = 1; i < 17; i++)
            chk(stb_time[i] - stb_time[i-1] == div, req, "strobe spacing",
                stb_time[i] - stb_time[i-1], div);
         chk(stb_data[16] == 8'h80, "R7", "underrun sample", stb_data[16], 8'h80);
      end
      chk(dac_sample == 8'h80, "R7", "idle output", dac_sample, 8'h80);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [2:0] exp_src;
      logic [7:0] hdr;
      logic [7:0] base;
      int         div;
      int         t_fill;

      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      mon_on = 1'b1;
      // R9: state after reset
      chk(dac_sample == 8'h80, "R9", "reset dac_sample", dac_sample, 8'h80);
      chk(dac_stb == 1'b0, "R9", "reset dac_stb", dac_stb, 0);
      chk(last_src_id == 3'd0, "R9", "reset last_src_id", last_src_id, 0);
      exp_src = 3'd0;

      // table walk: R1 address match, R2 wildcard, R3 skip, R6 rate
      for (int k = 0; k < 8; k++) begin
         station_id = VEC[k][11:9];
         hdr        = VEC[k][8:1];
         base       = 8'(8'h20 + 16 * k);
         div        = (hdr[7:6] == 2'b01) ? HI_DIV : LO_DIV;
         n_stb      = 0;
         send_byte(hdr);
         for (int i = 0; i < 16; i++) begin
            if (VEC[k][0]) send_byte(8'(base + i));
            else           send_byte({2'b00, station_id, 3'(i)});
         end
         repeat (DRAIN) @(negedge clk);
         if (VEC[k][0]) begin
            exp_src = hdr[2:0];
            verify_stream(base, div,
               (hdr[5:3] == 3'b111) ? "R2" : (hdr[7:6] == 2'b01 ? "R1" : "R6"));
         end else begin
            chk(n_stb == 0, "R3", "strobes from rejected packet", n_stb, 0);
         end
         chk(last_src_id == exp_src, "R8", "last source", last_src_id, exp_src);
      end

      // R5: threshold hold-off and exact first-strobe cycle
      station_id = 3'd2;
      n_stb = 0;
      send_byte({2'b01, 3'd2, 3'd6});
      for (int i = 0; i < 7; i++) send_byte(8'(8'h90 + i));
      repeat (300) @(negedge clk);
      chk(n_stb == 0, "R5", "strobes below threshold", n_stb, 0);
      @(negedge clk);
      t_fill  = cyc;
      rx_byte = 8'h97;
      rx_vld  = 1'b1;
      @(negedge clk);
      rx_vld  = 1'b0;
      for (int i = 8; i < 16; i++) send_byte(8'(8'h90 + i));
      repeat (DRAIN) @(negedge clk);
      chk(n_stb > 0 && stb_time[0] == t_fill + 2 + HI_DIV, "R5",
          "first strobe cycle", (n_stb > 0) ? stb_time[0] : -1, t_fill + 2 + HI_DIV);
      verify_stream(8'h90, HI_DIV, "R6");
      chk(last_src_id == 3'd6, "R8", "last source", last_src_id, 6);

      // R9: reset in the middle of a packet
      station_id = 3'd3;
      send_byte({2'b00, 3'd3, 3'd1});
      for (int i = 0; i < 5; i++) send_byte(8'(8'hA0 + i));
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(last_src_id == 3'd0, "R9", "last source after reset", last_src_id, 0);
      chk(dac_sample == 8'h80, "R9", "dac after reset", dac_sample, 8'h80);
      n_stb = 0;
      send_byte({2'b00, 3'd3, 3'd4});
      for (int i = 0; i < 16; i++) send_byte(8'(8'h60 + i));
      repeat (DRAIN) @(negedge clk);
      verify_stream(8'h60, LO_DIV, "R9");
      chk(last_src_id == 3'd4, "R9", "header found after reset", last_src_id, 4);

      // R10: output only moved together with a strobe
      chk(hold_bad == 0, "R10", "changes without strobe", hold_bad, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule